// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst static RAM. Each word is 36 bits wide and is split into four 9-bit lanes, each lane holding eight data bits and one parity bit. The array depth is set by an address-width parameter and is kept small for simulation. Address, chip selects and write controls are captured on the rising clock edge. Read data comes straight from the array through a tristate driver with no output register, so a word appears in the same cycle as the edge that selected it.

A burst can begin from either of two active-low start strobes. The processor strobe always starts a read and ignores the write controls. The controller strobe starts a cycle that also samples the write controls on the same edge. After a start, a 2-bit counter steps the two low address bits whenever the active-low advance input is low. A mode pin picks linear order (low bits plus count, modulo 4) or interleaved order (low bits XOR count). A write on a continuation edge lands on the address the burst reaches on that edge.

Top module: `fts_burst_sram`

## Requirements
- R1: With `all_wr_n` high and `lane_en_n` low, a write cycle stores only the lanes whose `lane_wr_n[i]` bit is low. Lane i is `dq[9i+8:9i]`, and bit 9i+8 is its parity bit. The other lanes keep their old contents.
- R2: With `all_wr_n` low, a write cycle stores all four lanes, whatever `lane_en_n` and `lane_wr_n` are.
- R3: With `all_wr_n` high and `lane_en_n` high, a write cycle changes no lane.
- R4: With `sel_n` low, an edge with `cpu_strobe_n` low and all selects active loads `addr` as the burst base. It resets the count to 0 and writes nothing, whatever the write controls are.
- R5: An edge with `ctl_strobe_n` low (and no processor start) and all selects active loads `addr` and writes the bus data to `addr` under the sampled write controls. A later edge with no start writes to the address the burst reaches on that same edge.
- R6: While `sel_n` is high, `cpu_strobe_n` has no effect. With `ctl_strobe_n` also high, the running burst and the bus output continue unchanged.
- R7: A start edge on which any of `sel_n` (active low), `sel_hi` (active high) or `sel2_n` (active low) is inactive deselects the block. The bus then floats, and continuation edges write nothing until the next selected start.
- R8: With `lin_mode` = 1, successive advance edges visit base low bits +1, +2, +3 modulo 4 and then wrap back to the base. The upper address bits stay fixed.
- R9: With `lin_mode` = 0, the low two address bits are the base low bits XOR the count. For a base ending in binary 01 this gives 1, 0, 3, 2, then 1 again.
- R10: An edge with no start and `step_n` high keeps the current burst address.
- R11: `dq` carries the word at the current burst address only while `oe_n` is low and the block is selected, and floats otherwise. Both output enable and the read path are combinational, and the reset state is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | External word address |
| cpu_strobe_n | input | 1 | Processor burst-start strobe, active low, read only |
| ctl_strobe_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_en_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | LANES | Per-lane write, active low |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The hardest cases to reach from the ports are the writes that must not happen. These are a processor-strobe edge that carries a full write pattern, and continuation edges after a deselect that carry one. Neither leaves any mark on the bus in its own cycle. The stimulus drives full write data with the global write low in those cycles, and later starts fresh read bursts over the affected words to show that the words kept their old contents. The two burst orders agree for bases ending in 00 and 10, so the order tests start from bases ending in 01 and 11, where linear and interleaved sequences differ.

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel2_n,
  input  logic                    lin_mode,
  input  logic                    oe_n,
  input  logic                    all_wr_n,
  input  logic                    lane_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  inout  wire  [LANES*LANE_W-1:0] dq
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     base;
  logic [1:0]        cnt;
  logic              active;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] c,
                                              input logic lin);
    logic [1:0] lo;
    lo = lin ? b[1:0] + c : b[1:0] ^ c;
    return {b[AW-1:2], lo};
  endfunction

  logic sel_ok, cpu_go, ctl_go, go, wr_cycle;
  logic [1:0] cnt_nxt;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [LANES-1:0] lane_sel, lane_we;

  assign sel_ok   = !sel_n && sel_hi && !sel2_n;
  assign cpu_go   = !cpu_strobe_n && !sel_n;
  assign ctl_go   = !ctl_strobe_n && !cpu_go;
  assign go       = cpu_go || ctl_go;
  assign cnt_nxt  = step_n ? cnt : cnt + 2'd1;
  assign rd_addr  = beat_addr(base, cnt, lin_mode);
  assign wr_addr  = ctl_go ? addr : beat_addr(base, cnt_nxt, lin_mode);
  assign wr_cycle = ctl_go ? sel_ok : (!go && active);
  assign lane_sel = !all_wr_n ? '1 : (!lane_en_n ? ~lane_wr_n : '0);
  assign lane_we  = wr_cycle ? lane_sel : '0;

  assign dq = (!oe_n && active) ? mem[rd_addr] : 'z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (go) begin
      active <= sel_ok;
      if (sel_ok) begin
        base <= addr;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (lane_we[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
  end

  p_cpu_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && sel_ok) |=> (active && base == $past(addr) && cnt == 2'd0))
    else $error("p_cpu_load_r4");
  p_cpu_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && sel_ok) |=> mem[base] == $past(mem[addr]))
    else $error("p_cpu_nowrite_r4");
  p_ctl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && sel_ok) |=> (active && base == $past(addr) && cnt == 2'd0))
    else $error("p_ctl_load_r5");
  p_cpu_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && ctl_strobe_n) |=> ($stable(active) && $stable(base)))
    else $error("p_cpu_ignored_r6");
  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !sel_ok) |=> !active)
    else $error("p_deselect_r7");
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !step_n) |=> cnt == $past(cnt) + 2'd1)
    else $error("p_step_r8");
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && step_n) |=> ($stable(cnt) && $stable(base)))
    else $error("p_hold_r10");
endmodule

// File: tb/fts_burst_sram_test.sv
`timescale 1ns/1ps
module fts_burst_sram_test;
  localparam int AW = 6;
  localparam logic [35:0] FLOAT = '1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic cpu_strobe_n = 1, ctl_strobe_n = 1, step_n = 1;
  logic sel_n = 0, sel_hi = 1, sel2_n = 0, lin_mode = 1, oe_n = 0;
  logic all_wr_n = 1, lane_en_n = 1;
  logic [3:0] lane_wr_n = 4'hF;
  logic tb_en = 0;
  logic [35:0] tb_dat = '0;
  wire  [35:0] dq;

  assign dq = tb_en ? tb_dat : 'z;
  for (genvar g = 0; g < 36; g++) begin : g_pu
    pullup (dq[g]);
  end

  fts_burst_sram #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi),
    .sel2_n(sel2_n), .lin_mode(lin_mode), .oe_n(oe_n), .all_wr_n(all_wr_n),
    .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .dq(dq));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic [35:0] v; string req; } item_t;
  item_t q[$];
  item_t mon_it;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [35:0] model [64];

  task automatic chk(input logic [35:0] got, input logic [35:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    while (q.size() > 0 && q[0].at <= cyc) begin
      mon_it = q.pop_front();
      chk(dq, mon_it.v, mon_it.req);
    end
  end

  task automatic expect_nx(input logic [35:0] v, input string req);
    q.push_back('{cyc + 1, v, req});
  endtask

  function automatic logic [35:0] pat(input int i);
    return {9'(i), 9'(i + 64), 9'(i + 128), 9'(i + 200)};
  endfunction

  function automatic int baddr(input int a, input int k, input bit lin);
    int lo;
    lo = lin ? ((a + k) & 3) : ((a & 3) ^ (k & 3));
    return (a & ~3) | lo;
  endfunction

  task automatic idle_sig();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1; oe_n = 0;
    all_wr_n = 1; lane_en_n = 1; lane_wr_n = 4'hF; tb_en = 0;
    sel_n = 0; sel_hi = 1; sel2_n = 0;
  endtask

  task automatic model_write(input int a, input logic [35:0] d, input bit gw, input bit bwe,
                             input logic [3:0] bw);
    for (int i = 0; i < 4; i++)
      if (!gw || (!bwe && !bw[i])) model[a][9*i +: 9] = d[9*i +: 9];
  endtask

  task automatic wr_start(input int a, input logic [35:0] d, input bit gw, input bit bwe,
                          input logic [3:0] bw);
    idle_sig();
    ctl_strobe_n = 0; addr = AW'(a); oe_n = 1;
    all_wr_n = gw; lane_en_n = bwe; lane_wr_n = bw; tb_en = 1; tb_dat = d;
    model_write(a, d, gw, bwe, bw);
    @(negedge clk);
  endtask

  task automatic wr_next(input int a, input logic [35:0] d, input bit gw, input bit bwe,
                         input logic [3:0] bw);
    idle_sig();
    step_n = 0; oe_n = 1;
    all_wr_n = gw; lane_en_n = bwe; lane_wr_n = bw; tb_en = 1; tb_dat = d;
    model_write(a, d, gw, bwe, bw);
    @(negedge clk);
  endtask

  task automatic rd_burst(input int a, input bit lin, input int n, input string req);
    lin_mode = lin;
    for (int k = 0; k < n; k++) begin
      idle_sig();
      if (k == 0) begin cpu_strobe_n = 0; addr = AW'(a); end
      else step_n = 0;
      expect_nx(model[baddr(a, k, lin)], req);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_sig();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state is deselected, bus floats with oe_n low
    expect_nx(FLOAT, "R11 reset float");
    @(negedge clk);

    for (int i = 0; i < 16; i++) wr_start(i, pat(i), 0, 1, 4'hF);

    rd_burst(5, 1, 5, "R8 linear from 5");
    rd_burst(7, 1, 5, "R8 linear from 7");
    rd_burst(5, 0, 5, "R9 interleaved from 5");
    rd_burst(7, 0, 5, "R9 interleaved from 7");

    // R10: hold with no strobe and step_n high
    lin_mode = 1;
    idle_sig(); cpu_strobe_n = 0; addr = AW'(9); expect_nx(model[9], "R10 start"); @(negedge clk);
    idle_sig(); step_n = 0; expect_nx(model[10], "R10 step"); @(negedge clk);
    idle_sig(); expect_nx(model[10], "R10 hold a"); @(negedge clk);
    idle_sig(); expect_nx(model[10], "R10 hold b"); @(negedge clk);
    idle_sig(); step_n = 0; expect_nx(model[11], "R10 step after hold"); @(negedge clk);

    // R6: processor strobe with sel_n high is ignored
    idle_sig(); sel_n = 1; cpu_strobe_n = 0; addr = AW'(0);
    expect_nx(model[11], "R6 cpu strobe ignored");
    @(negedge clk);

    // R11: asynchronous output enable
    idle_sig();
    oe_n = 1; #1 chk(dq, FLOAT, "R11 oe high floats");
    oe_n = 0; #1 chk(dq, model[11], "R11 oe low drives");
    idle_sig(); oe_n = 1; expect_nx(FLOAT, "R11 oe high beat"); @(negedge clk);

    // R1: lane writes, lanes 0 and 2 only
    wr_start(3, 36'h0_A5C3_96E1, 1, 0, 4'b1010);
    rd_burst(3, 1, 1, "R1 lane write");
    // R3: neither global nor lane enable
    wr_start(4, 36'h1_2345_6789, 1, 1, 4'h0);
    rd_burst(4, 1, 1, "R3 no write");
    // R2: global write overrides lane controls
    wr_start(8, 36'h0_DEAD_BEEF, 0, 1, 4'hF);
    rd_burst(8, 1, 1, "R2 global write");

    // R4: processor strobe start ignores write controls
    idle_sig(); cpu_strobe_n = 0; addr = AW'(2); oe_n = 1;
    all_wr_n = 0; tb_en = 1; tb_dat = 36'h0_1111_2222;
    @(negedge clk);
    idle_sig(); expect_nx(model[2], "R4 no write on cpu start"); @(negedge clk);

    // R5: controller start write then continuation writes
    lin_mode = 1;
    wr_start(12, 36'h0_0C0C_0C0C, 0, 1, 4'hF);
    wr_next(13, 36'h0_0D0D_0D0D, 0, 1, 4'hF);
    wr_next(14, 36'h0_EEEE_EEEE, 1, 0, 4'b0111);
    rd_burst(12, 1, 4, "R5 burst write");

    // R7: deselected start floats the bus and blocks continuation writes
    idle_sig(); ctl_strobe_n = 0; sel_hi = 0; addr = AW'(0);
    all_wr_n = 0; tb_en = 1; tb_dat = 36'h0_7777_7777; oe_n = 1;
    @(negedge clk);
    idle_sig(); expect_nx(FLOAT, "R7 float after deselect"); @(negedge clk);
    idle_sig(); step_n = 0; oe_n = 1; all_wr_n = 0; tb_en = 1; tb_dat = 36'h0_6666_6666;
    @(negedge clk);
    idle_sig(); ctl_strobe_n = 0; sel2_n = 1; expect_nx(FLOAT, "R7 float via sel2_n");
    @(negedge clk);
    rd_burst(0, 1, 1, "R7 word 0 unchanged");
    rd_burst(12, 1, 4, "R7 block unchanged");

    idle_sig();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule